// File: doc/BRIEF.md
# Strobe-Driven FIFO Buffer with Boundary Pass-Through

This block is a first-in first-out buffer for fixed-width words that is controlled by two active-low strobes rather than by clocked enables. Both strobes and a retransmit line are brought into the clock domain through a two-flop synchroniser and edge-detected. A write is granted while the write strobe is low and there is room, and the word is stored when the strobe rises. A read is granted while the read strobe is low and there is data: the word is presented with an output enable, and the read pointer advances when the strobe rises.

Empty, full and half-full flags follow the stored count. At the two boundaries the buffer passes data through. A read strobe that is already low on an empty buffer picks up the next written word a fixed number of cycles after that write completes. A write strobe that is held low on a full buffer is granted as soon as a read frees a slot, and it is committed when that strobe rises. A retransmit request rewinds the read pointer to location zero. The word width is a parameter, so several instances that share strobes can be placed side by side to make a wider word, and their flags stay in step.

Top module: `strobe_fifo`

## Requirements
- R1: After reset, empty is 1, full and half_full are 0, dout_en is 0 and dout is all zeros.
- R2: A write that is granted stores din as sampled two clock edges after wr_n rises. Words come out in the order they were written, and the pointers wrap past DEPTH-1 back to 0.
- R3: When wr_n or rd_n changes at the input, the change takes effect at the second rising clock edge after it. dout_en goes to 1 on that edge after a granted read begins and to 0 on that edge after rd_n rises. dout is all zeros whenever dout_en is 0.
- R4: empty is 1 exactly when the stored count is 0. half_full is 1 exactly when the count is greater than DEPTH/2. full is 1 when the count equals DEPTH, and also during the hold described in R7.
- R5: A read strobe on an empty buffer, or a write strobe on a full buffer, that ends before a grant is ignored. It moves no pointer, does not raise dout_en and does not change the stored contents.
- R6: Read pass-through: while rd_n is held low on an empty buffer, a completed write drops empty two edges after wr_n rises. The new word is driven with dout_en=1 three edges after wr_n rises. Once rd_n rises, empty returns to 1 two edges later.
- R7: Write pass-through: while wr_n is held low on a full buffer, a completed read clears full for exactly one cycle, starting two edges after rd_n rises. full then returns to 1, and the held word is stored when wr_n rises.
- R8: A rising edge on rt, seen while rt stays high and no strobe is granted, sets the read pointer to 0 and sets the count to the write pointer's index. The words from location 0 onward are then read again.
- R9: Instances that share the same strobes and reset give identical empty, full and half_full at every cycle, so one set of flags serves a wider word built from several instances.
- R10: WIDTH and DEPTH are parameters. DEPTH must be at least 2 and need not be a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears pointers and count |
| wr_n | input | 1 | Active-low write strobe, asynchronous to clk |
| rd_n | input | 1 | Active-low read strobe, asynchronous to clk |
| rt | input | 1 | Retransmit request, active high |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data, all zeros while dout_en is 0 |
| dout_en | output | 1 | Output drive enable, models the high-impedance bus when 0 |
| empty | output | 1 | Buffer holds no words |
| full | output | 1 | Buffer holds DEPTH words, or a held write is pending |
| half_full | output | 1 | Count is above DEPTH/2 |

## Verification
The bench runs a depth-8 pair of instances through fill, overflow, drain and wrap-around rounds. After every strobe it compares the flags with a count that the bench keeps itself, so a half-full threshold that is off by one, or a full flag that rises a word early, shows up at the exact count where it goes wrong. The two pass-through cases are timed edge by edge. A design that bypassed data too early, kept dout_en on after rd_n rose, or held full low for longer than one cycle (or never dropped it) fails the single-cycle samples around those edges. Ignored strobes and retransmit are checked through the words that come out afterwards: a design that advanced a pointer on a refused strobe, or rewound to the wrong place, returns the wrong word sequence.

// File: rtl/strobe_fifo_pkg.sv
`timescale 1ns/1ps
package strobe_fifo_pkg;

  // Synchronised strobe as seen inside the clock domain.
  typedef struct packed {
    logic level_low;  // synchronised line is low
    logic rise;       // synchronised line went low->high this cycle
  } strobe_ev_t;

  // Pointer step with wrap at an arbitrary depth.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Half-full threshold: strictly above half the depth.
  function automatic bit above_half(int unsigned cnt, int unsigned depth);
    return cnt > (depth / 2);
  endfunction

  // Count after one cycle of commits.
  function automatic int unsigned count_step(int unsigned cnt, bit wr, bit rd);
    return cnt + (wr ? 1 : 0) - (rd ? 1 : 0);
  endfunction

endpackage

// File: rtl/strobe_fifo_sync.sv
`timescale 1ns/1ps
module strobe_fifo_sync
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  output strobe_ev_t ev
);

  // hist[0] is the first capture flop, hist[STAGES-1] the synchronised
  // level, hist[STAGES] the previous synchronised level.
  logic [STAGES:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= {(STAGES+1){IDLE}};
    else        hist <= {hist[STAGES-1:0], pin};
  end

  assign ev.level_low = ~hist[STAGES-1];
  assign ev.rise      = hist[STAGES-1] & ~hist[STAGES];

  // R3: a detected rise cannot repeat on the following cycle
  p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev.rise |=> !ev.rise);

endmodule

// File: rtl/strobe_fifo_store.sv
`timescale 1ns/1ps
module strobe_fifo_store #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read: loaded once per granted read, held until the next.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/strobe_fifo_ctrl.sv
`timescale 1ns/1ps
module strobe_fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_ev_t    wr_ev,
  input  strobe_ev_t    rd_ev,
  input  strobe_ev_t    rt_ev,
  output logic          mem_we,
  output logic [AW-1:0] wp,
  output logic          mem_re,
  output logic [AW-1:0] rp,
  output logic          empty,
  output logic          full,
  output logic          half,
  output logic          out_en
);

  logic [CW-1:0] cnt;
  logic          wr_perm, rd_perm;
  logic          wr_wait, pt_hold, rt_req;

  // Named internal events.
  logic at_cap, wr_grant, wr_commit, rd_grant, rd_commit, rt_go;

  assign at_cap    = (cnt == CW'(DEPTH));
  assign wr_grant  = wr_ev.level_low & ~wr_perm & ~at_cap;
  assign wr_commit = wr_ev.rise & wr_perm;
  assign rd_grant  = rd_ev.level_low & ~rd_perm & (cnt != '0);
  assign rd_commit = rd_ev.rise & rd_perm;
  assign rt_go     = rt_req & ~wr_perm & ~rd_perm & ~wr_grant & ~rd_grant;

  assign mem_we = wr_commit;
  assign mem_re = rd_grant;

  // Write strobe permission and the full-boundary hold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_perm <= 1'b0;
      wr_wait <= 1'b0;
      pt_hold <= 1'b0;
    end else begin
      if (wr_commit)     wr_perm <= 1'b0;
      else if (wr_grant) wr_perm <= 1'b1;

      if (!wr_ev.level_low || wr_grant) wr_wait <= 1'b0;
      else if (at_cap && !wr_perm)      wr_wait <= 1'b1;

      if (wr_commit || !wr_perm && !wr_grant) pt_hold <= 1'b0;
      else if (wr_grant && wr_wait)           pt_hold <= 1'b1;
    end
  end

  // Read strobe permission.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_perm <= 1'b0;
    else if (rd_commit) rd_perm <= 1'b0;
    else if (rd_grant)  rd_perm <= 1'b1;
  end

  // Retransmit request: armed by a rise, dropped when the line falls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rt_req <= 1'b0;
    else if (rt_go)            rt_req <= 1'b0;
    else if (rt_ev.rise)       rt_req <= 1'b1;
    else if (rt_ev.level_low)  rt_req <= 1'b0;
  end

  // Pointers and count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (rt_go) begin
      rp  <= '0;
      cnt <= CW'(wp);
    end else begin
      if (wr_commit) wp <= AW'(ptr_step(32'(wp), DEPTH));
      if (rd_commit) rp <= AW'(ptr_step(32'(rp), DEPTH));
      cnt <= CW'(count_step(32'(cnt), wr_commit, rd_commit));
    end
  end

  assign empty  = (cnt == '0);
  assign full   = at_cap | pt_hold;
  assign half   = above_half(32'(cnt), DEPTH);
  assign out_en = rd_perm;

  // R4: the count never exceeds the depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R4: empty and full never together
  p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  // R4: half-full implies data present
  p_half_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    half |-> !empty);
  // R3: output enabled only with a word to show
  p_rd_perm_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_perm |-> !empty);
  // R2: a granted write always has a slot
  p_wr_perm_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_perm |-> (cnt < CW'(DEPTH)));
  // R5: a refused write leaves the write pointer alone
  p_ignored_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev.rise && !wr_perm) |=> $stable(wp));
  // R5: a refused read leaves the read pointer alone
  p_ignored_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev.rise && !rd_perm && !rt_go) |=> $stable(rp));
  // R8: retransmit rewinds the read pointer
  p_rt_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rt_go |=> (rp == '0));
  // R7: the full hold ends with the held write
  p_hold_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pt_hold && wr_commit) |=> (full && !pt_hold));

endmodule

// File: rtl/strobe_fifo.sv
`timescale 1ns/1ps
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned WIDTH       = 9,
  parameter int unsigned DEPTH       = 2048,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en,
  output logic             empty,
  output logic             full,
  output logic             half_full
);

  localparam int unsigned AW = $clog2(DEPTH);

  strobe_ev_t       wr_ev, rd_ev, rt_ev;
  logic             mem_we, mem_re;
  logic [AW-1:0]    wp, rp;
  logic [WIDTH-1:0] q;

  strobe_fifo_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .pin(wr_n), .ev(wr_ev));
  strobe_fifo_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .pin(rd_n), .ev(rd_ev));
  strobe_fifo_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_rt_sync (
    .clk(clk), .rst_n(rst_n), .pin(rt), .ev(rt_ev));

  strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .rd_ev(rd_ev), .rt_ev(rt_ev),
    .mem_we(mem_we), .wp(wp), .mem_re(mem_re), .rp(rp),
    .empty(empty), .full(full), .half(half_full), .out_en(dout_en));

  strobe_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(wp), .wdata(din),
    .re(mem_re), .raddr(rp), .rdata(q));

  assign dout = dout_en ? q : '0;

  // R3: a disabled output drives zeros
  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));

endmodule

// File: tb/sim_strobe_fifo.sv
`timescale 1ns/1ps
module sim_strobe_fifo;

  localparam int W = 9;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, rt = 1'b0;
  logic [W-1:0] din0 = '0, din1 = '0;
  logic [W-1:0] dout0, dout1;
  logic en0, en1, em0, em1, fu0, fu1, hf0, hf1;

  always #2.5 clk = ~clk;

  strobe_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt(rt), .din(din0),
    .dout(dout0), .dout_en(en0), .empty(em0), .full(fu0), .half_full(hf0));
  strobe_fifo #(.WIDTH(W), .DEPTH(D)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt(rt), .din(din1),
    .dout(dout1), .dout_en(en1), .empty(em1), .full(fu1), .half_full(hf1));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [W-1:0] mq[$];
  int wseq = 0;

  function automatic logic [W-1:0] word(int i);
    return W'((i * 53 + 17) % 512);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Flags from the bench's own count; second instance must match (R9).
  task automatic chk_flags(string req);
    int c = mq.size();
    chk(em0 == (c == 0), req, "empty", int'(em0), int'(c == 0));
    chk(fu0 == (c == D), req, "full", int'(fu0), int'(c == D));
    chk(hf0 == (c > D / 2), req, "half_full", int'(hf0), int'(c > D / 2));
    chk({em1, fu1, hf1} == {em0, fu0, hf0}, "R9", "flags u1 vs u0",
        int'({em1, fu1, hf1}), int'({em0, fu0, hf0}));
  endtask

  task automatic do_write(string req);
    logic [W-1:0] v = word(wseq++);
    bit room = (mq.size() < D);
    din0 = v; din1 = ~v;
    wr_n = 1'b0; tick(3);
    wr_n = 1'b1; tick(3);
    if (room) mq.push_back(v);
    chk_flags(req);
  endtask

  task automatic do_read(string req);
    rd_n = 1'b0; tick(3);
    if (mq.size() > 0) begin
      chk(en0 == 1'b1, "R3", "dout_en on read", int'(en0), 1);
      chk(dout0 == mq[0], req, "read word", int'(dout0), int'(mq[0]));
      chk(dout1 == W'(~mq[0]), "R9", "read word u1", int'(dout1), int'(W'(~mq[0])));
    end else begin
      chk(en0 == 1'b0, "R5", "dout_en on empty read", int'(en0), 0);
      chk(dout0 == '0, "R3", "idle bus", int'(dout0), 0);
    end
    rd_n = 1'b1; tick(3);
    if (mq.size() > 0) void'(mq.pop_front());
    chk(en0 == 1'b0, "R3", "dout_en after rise", int'(en0), 0);
    chk_flags(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(2);
    mq.delete();
  endtask

  initial begin
    logic [W-1:0] pv;
    tick(3);
    // R1: reset state
    chk({em0, fu0, hf0, en0} == 4'b1000, "R1", "flags after reset",
        int'({em0, fu0, hf0, en0}), 8);
    chk(dout0 == '0, "R1", "dout after reset", int'(dout0), 0);
    rst_n = 1'b1; tick(2);
    chk_flags("R1");

    // R4/R2: fill sweep, one extra write refused (R5), then drain
    for (int i = 0; i < D; i++) do_write("R4");
    do_write("R5");
    for (int i = 0; i < D; i++) do_read("R2");
    chk(mq.size() == 0 && em0 == 1'b1, "R5", "empty after drain", int'(em0), 1);

    // R5: read on empty ignored, then one word round trip
    do_read("R5");
    do_write("R5");
    do_read("R5");

    // R2/R10: wrap-around rounds at uneven fill levels
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 5 + r % 3; i++) do_write("R10");
      for (int i = 0; i < 5 + r % 3; i++) do_read("R2");
    end

    // R6: read pass-through on empty buffer
    rd_n = 1'b0; tick(4);
    chk(en0 == 1'b0 && em0 == 1'b1, "R6", "waiting read idle", int'(en0), 0);
    pv = word(wseq++); din0 = pv; din1 = ~pv;
    wr_n = 1'b0; tick(3);
    wr_n = 1'b1; tick(2);
    chk(em0 == 1'b1, "R6", "empty before commit", int'(em0), 1);
    tick(1);
    chk(em0 == 1'b0 && en0 == 1'b0, "R6", "empty drops, no drive yet",
        int'({em0, en0}), 0);
    tick(1);
    chk(en0 == 1'b1 && dout0 == pv, "R6", "pass-through word", int'(dout0), int'(pv));
    chk(em1 == em0 && en1 == 1'b1, "R9", "u1 pass-through", int'(en1), 1);
    rd_n = 1'b1; tick(2);
    chk(en0 == 1'b1, "R6", "held until rise seen", int'(en0), 1);
    tick(1);
    chk(en0 == 1'b0 && em0 == 1'b1, "R6", "empty reasserts", int'({en0, em0}), 1);

    // R7: write pass-through on full buffer
    for (int i = 0; i < D; i++) do_write("R7");
    pv = word(wseq++); din0 = pv; din1 = ~pv;
    wr_n = 1'b0; tick(4);
    chk(fu0 == 1'b1, "R7", "full while write waits", int'(fu0), 1);
    rd_n = 1'b0; tick(3);
    chk(dout0 == mq[0], "R7", "read at full", int'(dout0), int'(mq[0]));
    rd_n = 1'b1; tick(3);
    void'(mq.pop_front());
    chk(fu0 == 1'b0, "R7", "full drops one cycle", int'(fu0), 0);
    chk(fu1 == fu0, "R9", "u1 full pulse", int'(fu1), int'(fu0));
    tick(1);
    chk(fu0 == 1'b1, "R7", "full reasserts", int'(fu0), 1);
    wr_n = 1'b1; tick(3);
    mq.push_back(pv);
    chk_flags("R7");
    for (int i = 0; i < D; i++) do_read("R7");

    // R8: retransmit rewinds to location 0
    do_reset();
    chk_flags("R1");
    begin
      logic [W-1:0] saved[3];
      for (int i = 0; i < 3; i++) begin
        saved[i] = word(wseq);
        do_write("R8");
      end
      do_read("R8");
      do_read("R8");
      rt = 1'b1; tick(3);
      rt = 1'b0; tick(2);
      mq.delete();
      for (int i = 0; i < 3; i++) mq.push_back(saved[i]);
      chk_flags("R8");
      for (int i = 0; i < 3; i++) do_read("R8");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule